// File: doc/BRIEF.md
# Processor Interrupt Entry Sequencer

This block is the part of a small 16-bit processor core that decides, at each instruction boundary, whether to leave the running program for a service routine, and then carries out that entry step by step. Four kinds of request compete: an internal fault raised by the execution unit, an edge-triggered non-maskable request, a software interrupt instruction carrying its own type number, and a level-sensitive maskable request from an external interrupt controller. The maskable request only counts while the interrupt-enable flag is set.

Once a request is chosen, the sequencer obtains an 8-bit type number. An external request gets its type through a handshake of two active-low acknowledge pulses, and the type is read from the data lines during the second pulse. Every other source supplies its type directly, with no acknowledge pulses. The sequencer then asks the stack datapath to save the flags. It strobes the clearing of the interrupt-enable and trap flags, and then asks for the code segment and instruction pointer to be saved. After that it reads the vector table entry at four times the type number as two 16-bit words. The lower word is the new instruction pointer and the upper word is the new code segment. Both are presented together with a one-cycle strobe.

Top module: `intr_entry_seq`

## Requirements
- R1: After reset `busy`, `push_stb`, `flags_clr`, `mem_rd` and `vec_valid` are 0 and `inta_n` is 1.
- R2: The maskable request `intr_req` starts an entry only in a cycle where `insn_end` is 1 and `flag_ie` is 1. With `flag_ie` at 0, or without `insn_end`, it leaves `busy` low.
- R3: An external entry drives `inta_n` low for exactly two single-cycle pulses, separated by one high cycle. The type number is taken from `ack_data[7:0]` in the cycle of the second pulse. What `ack_data` holds during the first pulse has no effect.
- R4: A rising edge on `nmi_in` is remembered even if the pulse ends before the next boundary. It is taken at the next `insn_end` with type 2, regardless of `flag_ie` and without acknowledge pulses. It is taken only once per edge.
- R5: A software interrupt (`swi_req`) is taken at `insn_end` with type `swi_type`, regardless of `flag_ie` and without acknowledge pulses.
- R6: When several requests are present at one boundary, the order is fault, then non-maskable, then software, then maskable.
- R7: Entry issues `push_stb` in consecutive cycles in this order: flags (`push_sel`=0), then a one-cycle `flags_clr` with no push, then code segment (`push_sel`=1), then instruction pointer (`push_sel`=2).
- R8: The table is read as two 16-bit words: byte address 4×type first, then 4×type+2. Each read holds `mem_rd` and `mem_addr` steady until `mem_rvalid` is 1.
- R9: `vec_valid` is high for exactly one cycle. In that cycle `new_ip` holds the first word read and `new_cs` holds the second.
- R10: `busy` is high from the cycle after the accepted boundary through the `vec_valid` cycle, and low in the cycle after. While `busy` is high, `insn_end` and all requests are ignored.
- R11: An internal fault (`fault_req`) is taken at `insn_end` with type `fault_type`, without acknowledge pulses, regardless of `flag_ie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_end | input | 1 | High in the last cycle of an instruction |
| flag_ie | input | 1 | Current interrupt-enable flag |
| fault_req | input | 1 | Internal fault request |
| fault_type | input | 8 | Type number of the fault |
| nmi_in | input | 1 | Non-maskable request, rising-edge triggered |
| swi_req | input | 1 | Software interrupt instruction completing |
| swi_type | input | 8 | Type number of the software interrupt |
| intr_req | input | 1 | Maskable external request, level-sensitive |
| inta_n | output | 1 | Acknowledge pulse, active low |
| ack_data | input | 8 | Type number from the external controller |
| push_stb | output | 1 | Push request to the stack datapath |
| push_sel | output | 2 | What to push: 0 flags, 1 code segment, 2 instruction pointer |
| flags_clr | output | 1 | Clear interrupt-enable and trap flags |
| mem_rd | output | 1 | Vector table read request |
| mem_addr | output | 20 | Byte address of the word being read |
| mem_rdata | input | 16 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| new_cs | output | 16 | New code segment |
| new_ip | output | 16 | New instruction pointer |
| vec_valid | output | 1 | New code segment and pointer are valid |
| busy | output | 1 | Entry sequence in progress |

## Verification
The hardest case to produce from the ports is a non-maskable pulse that arrives and goes away while another entry is still running. It must neither disturb that entry nor be lost, and it must be taken at a later boundary exactly once. The bench starts a software entry, fires a one-cycle `nmi_in` pulse in the middle of it, and also raises a boundary strobe and an enabled maskable request in the middle of it. It then confirms that `busy` stays low after completion until a bare boundary arrives, that this boundary produces a type-2 table read, and that a further bare boundary does nothing. The acknowledge data is changed between the two pulses, so a capture on the wrong pulse is seen in the table address.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ACK1, S_GAP, S_ACK2, S_PUSH_F, S_CLR,
    S_PUSH_CS, S_PUSH_IP, S_RD_LO, S_RD_HI, S_DONE
  } seq_state_e;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_FAULT, SRC_NMI, SRC_SWI, SRC_EXT
  } src_e;

  localparam logic [1:0] PSEL_FLAGS = 2'd0;
  localparam logic [1:0] PSEL_CS    = 2'd1;
  localparam logic [1:0] PSEL_IP    = 2'd2;

  // Byte address of a table word: four bytes per entry, upper word at +2.
  function automatic logic [31:0] tbl_byte_addr(input logic [15:0] vtype,
                                                input logic upper);
    logic [31:0] base;
    base = {16'd0, vtype} << 2;
    return base + (upper ? 32'd2 : 32'd0);
  endfunction

endpackage

// File: rtl/intr_nmi_latch.sv
module intr_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic take,
  output logic pend
);
  logic nmi_q;
  logic nmi_rise;

  assign nmi_rise = nmi_in & ~nmi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      nmi_q <= nmi_in;
      pend  <= (pend & ~take) | nmi_rise;
    end
  end

  // R4
  nmi_edge_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_in) |=> pend);

  // R4
  nmi_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !nmi_rise) |=> !pend);

endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import intr_seq_pkg::*;
#(
  parameter int TYPE_W   = 8,
  parameter int NMI_TYPE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_req,
  input  logic [TYPE_W-1:0] fault_type,
  input  logic              nmi_pend,
  input  logic              swi_req,
  input  logic [TYPE_W-1:0] swi_type,
  input  logic              intr_req,
  input  logic              flag_ie,
  output src_e              src,
  output logic [TYPE_W-1:0] sel_type
);
  localparam logic [TYPE_W-1:0] NMI_T = TYPE_W'(NMI_TYPE);

  always_comb begin
    src      = SRC_NONE;
    sel_type = '0;
    if (fault_req) begin
      src      = SRC_FAULT;
      sel_type = fault_type;
    end else if (nmi_pend) begin
      src      = SRC_NMI;
      sel_type = NMI_T;
    end else if (swi_req) begin
      src      = SRC_SWI;
      sel_type = swi_type;
    end else if (intr_req && flag_ie) begin
      src      = SRC_EXT;
    end
  end

  // R2
  ext_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_EXT) |-> (flag_ie && intr_req && !swi_req && !nmi_pend));

  // R6
  nmi_over_swi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !fault_req) |-> (src == SRC_NMI));

endmodule

// File: rtl/intr_entry_fsm.sv
module intr_entry_fsm
  import intr_seq_pkg::*;
#(
  parameter int TYPE_W = 8,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_end,
  input  src_e              src,
  input  logic [TYPE_W-1:0] sel_type,
  output logic              take_nmi,
  output logic              inta_n,
  input  logic [TYPE_W-1:0] ack_data,
  output logic              push_stb,
  output logic [1:0]        push_sel,
  output logic              flags_clr,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_rvalid,
  output logic [WORD_W-1:0] new_cs,
  output logic [WORD_W-1:0] new_ip,
  output logic              vec_valid,
  output logic              busy
);
  seq_state_e        state, nxt;
  logic [TYPE_W-1:0] type_q;
  logic              accept;

  // Named internal events for the checks below.
  assign accept   = (state == S_IDLE) && insn_end && (src != SRC_NONE);
  assign take_nmi = accept && (src == SRC_NMI);

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:    if (accept) nxt = (src == SRC_EXT) ? S_ACK1 : S_PUSH_F;
      S_ACK1:    nxt = S_GAP;
      S_GAP:     nxt = S_ACK2;
      S_ACK2:    nxt = S_PUSH_F;
      S_PUSH_F:  nxt = S_CLR;
      S_CLR:     nxt = S_PUSH_CS;
      S_PUSH_CS: nxt = S_PUSH_IP;
      S_PUSH_IP: nxt = S_RD_LO;
      S_RD_LO:   if (mem_rvalid) nxt = S_RD_HI;
      S_RD_HI:   if (mem_rvalid) nxt = S_DONE;
      S_DONE:    nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      type_q <= '0;
      new_ip <= '0;
      new_cs <= '0;
    end else begin
      state <= nxt;
      if (accept && (src != SRC_EXT)) type_q <= sel_type;
      if (state == S_ACK2)            type_q <= ack_data;
      if ((state == S_RD_LO) && mem_rvalid) new_ip <= mem_rdata;
      if ((state == S_RD_HI) && mem_rvalid) new_cs <= mem_rdata;
    end
  end

  assign busy      = (state != S_IDLE);
  assign inta_n    = !((state == S_ACK1) || (state == S_ACK2));
  assign push_stb  = (state == S_PUSH_F) || (state == S_PUSH_CS) ||
                     (state == S_PUSH_IP);
  assign push_sel  = (state == S_PUSH_CS) ? PSEL_CS :
                     (state == S_PUSH_IP) ? PSEL_IP : PSEL_FLAGS;
  assign flags_clr = (state == S_CLR);
  assign mem_rd    = (state == S_RD_LO) || (state == S_RD_HI);
  assign mem_addr  = ADDR_W'(tbl_byte_addr(16'(type_q), state == S_RD_HI));
  assign vec_valid = (state == S_DONE);

  // R3
  inta_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inta_n |=> inta_n);

  // R7
  clr_after_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_stb && push_sel == PSEL_FLAGS) |=> (flags_clr && !push_stb));

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_rvalid) |=> (mem_rd && $stable(mem_addr)));

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> (!vec_valid && !busy));

  // R10
  busy_from_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(insn_end));

  // R10
  no_boundary_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !insn_end) |=> !busy);

endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
  import intr_seq_pkg::*;
#(
  parameter int TYPE_W   = 8,
  parameter int WORD_W   = 16,
  parameter int ADDR_W   = 20,
  parameter int NMI_TYPE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_end,
  input  logic              flag_ie,
  input  logic              fault_req,
  input  logic [TYPE_W-1:0] fault_type,
  input  logic              nmi_in,
  input  logic              swi_req,
  input  logic [TYPE_W-1:0] swi_type,
  input  logic              intr_req,
  output logic              inta_n,
  input  logic [TYPE_W-1:0] ack_data,
  output logic              push_stb,
  output logic [1:0]        push_sel,
  output logic              flags_clr,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_rvalid,
  output logic [WORD_W-1:0] new_cs,
  output logic [WORD_W-1:0] new_ip,
  output logic              vec_valid,
  output logic              busy
);
  logic              nmi_pend;
  logic              take_nmi;
  src_e              src;
  logic [TYPE_W-1:0] sel_type;

  intr_nmi_latch u_nmi (
    .clk    (clk),
    .rst_n  (rst_n),
    .nmi_in (nmi_in),
    .take   (take_nmi),
    .pend   (nmi_pend)
  );

  intr_arbiter #(.TYPE_W(TYPE_W), .NMI_TYPE(NMI_TYPE)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_req  (fault_req),
    .fault_type (fault_type),
    .nmi_pend   (nmi_pend),
    .swi_req    (swi_req),
    .swi_type   (swi_type),
    .intr_req   (intr_req),
    .flag_ie    (flag_ie),
    .src        (src),
    .sel_type   (sel_type)
  );

  intr_entry_fsm #(.TYPE_W(TYPE_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_end   (insn_end),
    .src        (src),
    .sel_type   (sel_type),
    .take_nmi   (take_nmi),
    .inta_n     (inta_n),
    .ack_data   (ack_data),
    .push_stb   (push_stb),
    .push_sel   (push_sel),
    .flags_clr  (flags_clr),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .mem_rvalid (mem_rvalid),
    .new_cs     (new_cs),
    .new_ip     (new_ip),
    .vec_valid  (vec_valid),
    .busy       (busy)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (!busy && inta_n && !push_stb && !mem_rd && !vec_valid));

endmodule

// File: tb/intr_entry_seq_tb.sv
`timescale 1ns/1ps
module intr_entry_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_end = 0, flag_ie = 0, fault_req = 0, nmi_in = 0;
  logic        swi_req = 0, intr_req = 0, mem_rvalid;
  logic [7:0]  fault_type = 0, swi_type = 0, ack_data = 8'hEE;
  logic        inta_n, push_stb, flags_clr, mem_rd, vec_valid, busy;
  logic [1:0]  push_sel;
  logic [19:0] mem_addr;
  logic [15:0] mem_rdata, new_cs, new_ip;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  intr_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .insn_end(insn_end), .flag_ie(flag_ie),
    .fault_req(fault_req), .fault_type(fault_type), .nmi_in(nmi_in),
    .swi_req(swi_req), .swi_type(swi_type), .intr_req(intr_req),
    .inta_n(inta_n), .ack_data(ack_data), .push_stb(push_stb),
    .push_sel(push_sel), .flags_clr(flags_clr), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .new_cs(new_cs), .new_ip(new_ip), .vec_valid(vec_valid), .busy(busy)
  );

  function automatic logic [15:0] mem_word(input logic [19:0] a);
    return a[15:0] * 16'd7 + 16'h1234;
  endfunction

  // Vector table model: one cycle from request to data.
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      mem_rvalid <= mem_rd && !mem_rvalid;
      mem_rdata  <= mem_word(mem_addr);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic       fault, nmi, swi, intr, ie;
    logic [7:0] ftype, stype, atype, etype;
    logic       ext;
  } case_t;

  localparam int NCASE = 9;
  localparam case_t CASES [NCASE] = '{
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 8'h00,8'h00,8'h21,8'h21, 1'b1}, // R2 R3 external
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 8'h00,8'h00,8'hFF,8'hFF, 1'b1}, // R3 top type
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00,8'h50,8'h00,8'h50, 1'b0}, // R5 IF clear
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h02, 1'b0}, // R4 short pulse
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 8'h00,8'h60,8'h33,8'h00, 1'b0}, // R6 R11 all
    '{1'b0,1'b1,1'b1,1'b1,1'b1, 8'h00,8'h61,8'h34,8'h02, 1'b0}, // R6 nmi wins
    '{1'b0,1'b0,1'b1,1'b1,1'b1, 8'h00,8'h80,8'h35,8'h80, 1'b0}, // R6 swi wins
    '{1'b0,1'b0,1'b1,1'b1,1'b0, 8'h00,8'h03,8'h36,8'h03, 1'b0}, // R2 R5 masked ext
    '{1'b1,1'b0,1'b0,1'b0,1'b1, 8'h04,8'h00,8'h00,8'h04, 1'b0}  // R11 fault type
  };

  task automatic clear_reqs();
    fault_req = 0; swi_req = 0; intr_req = 0; nmi_in = 0; insn_end = 0;
  endtask

  task automatic run_case(input case_t c);
    int pulses = 0, low_cycles = 0, nvalid = 0;
    int kpf = -1, kclr = -1, kcs = -1, kip = -1;
    bit prev_n = 1, got_lo = 0, got_hi = 0;
    logic [19:0] lo_a = 0, hi_a = 0, exp_lo;
    logic [15:0] ip = 0, cs = 0;
    @(negedge clk);
    if (c.nmi) begin
      nmi_in = 1; @(negedge clk); nmi_in = 0; @(negedge clk);
    end
    flag_ie = c.ie; fault_req = c.fault; fault_type = c.ftype;
    swi_req = c.swi; swi_type = c.stype; intr_req = c.intr; insn_end = 1;
    @(negedge clk);
    insn_end = 0;
    for (int k = 0; k < 40 && nvalid == 0; k++) begin
      if (!inta_n) begin
        low_cycles++;
        if (prev_n) pulses++;
        ack_data = (pulses == 2) ? c.atype : 8'hEE;
      end else ack_data = 8'hEE;
      prev_n = inta_n;
      if (push_stb) begin
        if (push_sel == 2'd0) kpf = k;
        else if (push_sel == 2'd1) kcs = k;
        else if (push_sel == 2'd2) kip = k;
      end
      if (flags_clr) kclr = k;
      if (mem_rd) begin
        if (!got_lo) begin lo_a = mem_addr; got_lo = 1; end
        else if (!got_hi && mem_addr != lo_a) begin hi_a = mem_addr; got_hi = 1; end
      end
      if (vec_valid) begin nvalid++; ip = new_ip; cs = new_cs; end
      @(negedge clk);
    end
    exp_lo = {10'd0, c.etype, 2'b00};
    chk(pulses == (c.ext ? 2 : 0), "R3 acknowledge pulse count", pulses, c.ext ? 2 : 0);
    chk(low_cycles == pulses, "R3 pulse width", low_cycles, pulses);
    chk(lo_a == exp_lo, "R4/R5/R6/R11 type via low-word address", lo_a, exp_lo);
    chk(hi_a == exp_lo + 2, "R8 high-word address", hi_a, exp_lo + 2);
    chk(kclr == kpf + 1 && kcs == kpf + 2 && kip == kpf + 3 && kpf >= 0,
        "R7 push order", {kpf[7:0], kclr[7:0], kcs[7:0], kip[7:0]}, kpf + 1);
    chk(nvalid == 1, "R9 valid strobe count", nvalid, 1);
    chk(ip == mem_word(exp_lo), "R9 new_ip", ip, mem_word(exp_lo));
    chk(cs == mem_word(exp_lo + 2), "R9 new_cs", cs, mem_word(exp_lo + 2));
    chk(!busy && !vec_valid, "R10 busy low after done", busy, 0);
    clear_reqs();
  endtask

  initial begin
    case_t idle_c;
    int nv, np;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && inta_n && !push_stb && !flags_clr && !mem_rd && !vec_valid,
        "R1 reset outputs", {busy, inta_n, push_stb, flags_clr, mem_rd, vec_valid}, 6'b010000);

    for (int i = 0; i < NCASE; i++) run_case(CASES[i]);

    // R2 masked: IF clear with a boundary
    flag_ie = 0; intr_req = 1; insn_end = 1;
    @(negedge clk); insn_end = 0;
    np = 0;
    for (int k = 0; k < 6; k++) begin
      if (busy || !inta_n) np++;
      @(negedge clk);
    end
    chk(np == 0, "R2 masked request ignored", np, 0);
    // R2 no boundary
    flag_ie = 1;
    np = 0;
    for (int k = 0; k < 6; k++) begin
      if (busy) np++;
      @(negedge clk);
    end
    chk(np == 0, "R2 no entry without boundary", np, 0);
    clear_reqs();

    // R10 R4: requests while busy are ignored; NMI pulse kept for later
    @(negedge clk);
    swi_req = 1; swi_type = 8'h10; insn_end = 1;
    @(negedge clk);
    insn_end = 0;
    chk(busy, "R10 busy after boundary", busy, 1);
    @(negedge clk); @(negedge clk);
    nmi_in = 1; intr_req = 1; flag_ie = 1; insn_end = 1;
    @(negedge clk);
    nmi_in = 0; insn_end = 0;
    nv = 0; np = 0;
    for (int k = 0; k < 30 && busy; k++) begin
      if (vec_valid) nv++;
      if (!inta_n) np++;
      @(negedge clk);
    end
    chk(nv == 1 && np == 0, "R10 mid-sequence boundary ignored", {nv[15:0], np[15:0]}, 32'h10000);
    clear_reqs();
    np = 0;
    for (int k = 0; k < 4; k++) begin
      if (busy) np++;
      @(negedge clk);
    end
    chk(np == 0, "R4 latched edge waits for boundary", np, 0);
    idle_c = '{1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h02, 1'b0};
    run_case(idle_c);  // R4 latched edge taken as type 2
    // R4 taken only once
    insn_end = 1; @(negedge clk); insn_end = 0;
    np = 0;
    for (int k = 0; k < 4; k++) begin
      if (busy) np++;
      @(negedge clk);
    end
    chk(np == 0, "R4 no second entry for one edge", np, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule